// File: doc/BRIEF.md
# Offset-Coded Programmable Clock Divider

This block divides its input clock by a whole number taken from a 7-bit static configuration word. The divide ratio is the word value plus a fixed offset of two, so the legal word range 1 to 127 gives ratios from 3 to 129. Each output period has a short active-low window of exactly two input cycles. The output is high for the rest of the period, so the duty cycle depends on the ratio. At a ratio of 20, for example, the output is high 18 cycles out of 20, which is 90%.

One down-counter sets the period. It reloads from the configuration word only at the end of a period, so a change to the word partway through a period does not disturb that period. The output comes straight from a flip-flop. A word of zero is illegal. The block runs it as a word of one and raises a sticky error flag that only reset clears.

Top module: `clkdiv_offset`

## Requirements
- R1: The output period, measured in input clock cycles, equals the word value plus 2.
- R2: Every word value from 1 to 127 is accepted, giving ratios from 3 to 129.
- R3: In every output period, `div_out` is low for exactly 2 consecutive input cycles and high for the other ratio−2 cycles. At word 18 (ratio 20) it is high 18 of 20 cycles.
- R4: While `rst` is high, `div_out` is held high. After `rst` falls, `div_out` first goes low after exactly ratio−2 clock edges.
- R5: The word is sampled only at the end of a period (and while `rst` is high). A change partway through a period leaves that period's length unchanged and takes effect from the next period.
- R6: A word value of 0 runs the divider at ratio 3, the same as a word of 1.
- R7: `cfg_err` is 0 after reset. It goes high from the cycle after any non-reset clock edge at which the word is 0, and stays high until the next reset, whatever the word does in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_word | input | 7 | Configuration word; ratio = word + 2 |
| div_out | output | 1 | Divided clock, registered, low 2 cycles per period |
| cfg_err | output | 1 | Sticky flag: an illegal word of 0 was seen |

## Verification
Both outputs are registered, so each result shows up one clock edge after the edge that causes it. The bench drives inputs and samples outputs on the falling edge, and it counts rising edges to measure timing. The first low window begins at the (ratio−2)th edge after reset is released, lasts two edges, and the next low begins ratio−2 edges after the output rises again. The error flag is checked one edge after a zero word is applied. A changed word is checked only in the period after the reload edge, and the bench lets a whole low window pass first, so each measurement sits on an edge that the requirements fix.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Default geometry of the divider
    localparam int unsigned DEF_WORD_W  = 7;
    localparam int unsigned DEF_OFFSET  = 2;
    localparam int unsigned DEF_LOW_CYC = 2;

    // Output level encoding
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    // Per-cycle counter events
    typedef struct packed {
        logic terminal;   // counter at zero this cycle
        logic reload;     // counter loads a fresh period next edge
    } cnt_evt_t;

    // Width needed for a count up to and including max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= 64'(max_val)) begin
            w = w + 1;
        end
        return w;
    endfunction

    // Largest ratio reachable with a given word width and offset
    function automatic int unsigned max_ratio(input int unsigned word_w,
                                              input int unsigned offset);
        return ((1 << word_w) - 1) + offset;
    endfunction

endpackage

// File: rtl/cfg_guard.sv
module cfg_guard #(
    parameter int unsigned WORD_W = clkdiv_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_eff,
    output logic              err_flag
);
    localparam logic [WORD_W-1:0] MIN_LEGAL = WORD_W'(1);

    logic illegal;
    logic err_q;

    assign illegal  = (word_in == '0);
    assign word_eff = illegal ? MIN_LEGAL : word_in;

    // Sticky error: set on any non-reset edge that sees a zero word
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (illegal) begin
            err_q <= 1'b1;
        end
    end

    assign err_flag = err_q;

endmodule

// File: rtl/period_ctr.sv
module period_ctr
    import clkdiv_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned OFFSET = DEF_OFFSET,
    parameter int unsigned CNT_W  = cnt_width(max_ratio(DEF_WORD_W, DEF_OFFSET))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_eff,
    output logic [CNT_W-1:0]  cnt_nxt,
    output cnt_evt_t          evt
);
    // A period of N cycles counts N-1 down to 0
    localparam logic [CNT_W-1:0] LOAD_ADD = CNT_W'(OFFSET - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val     = CNT_W'(word_eff) + LOAD_ADD;
    assign evt.terminal = (cnt_q == '0);
    assign evt.reload   = rst | evt.terminal;

    always_comb begin
        if (evt.reload) begin
            cnt_nxt = load_val;
        end else begin
            cnt_nxt = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/pulse_out.sv
module pulse_out
    import clkdiv_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LOW_CYC = DEF_LOW_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] LOW_LIM = CNT_W'(LOW_CYC);

    lvl_e lvl_d;
    lvl_e lvl_q;

    // Low window occupies the last LOW_CYC counts of each period
    generate
        if (LOW_CYC == 0) begin : g_no_low
            assign lvl_d = LVL_HIGH;
        end else begin : g_low
            assign lvl_d = (cnt_nxt < LOW_LIM) ? LVL_LOW : LVL_HIGH;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= LVL_HIGH;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign pulse = (lvl_q == LVL_HIGH);

endmodule

// File: rtl/clkdiv_offset.sv
module clkdiv_offset
    import clkdiv_pkg::*;
#(
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned OFFSET  = DEF_OFFSET,
    parameter int unsigned LOW_CYC = DEF_LOW_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ratio_word,
    output logic              div_out,
    output logic              cfg_err
);
    localparam int unsigned CNT_W = cnt_width(max_ratio(WORD_W, OFFSET));

    logic [WORD_W-1:0] word_eff;
    logic [CNT_W-1:0]  cnt_nxt;
    cnt_evt_t          evt;

    cfg_guard #(
        .WORD_W (WORD_W)
    ) u_guard (
        .clk      (clk),
        .rst      (rst),
        .word_in  (ratio_word),
        .word_eff (word_eff),
        .err_flag (cfg_err)
    );

    period_ctr #(
        .WORD_W (WORD_W),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .word_eff (word_eff),
        .cnt_nxt  (cnt_nxt),
        .evt      (evt)
    );

    pulse_out #(
        .CNT_W   (CNT_W),
        .LOW_CYC (LOW_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .pulse   (div_out)
    );

endmodule

// File: rtl/clkdiv_offset_chk.sv
module clkdiv_offset_chk #(
    parameter int unsigned WORD_W  = 7,
    parameter int unsigned OFFSET  = 2,
    parameter int unsigned LOW_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] ratio_word,
    input logic              div_out,
    input logic              cfg_err
);
    localparam int unsigned HI_MAX = ((1 << WORD_W) - 1) + OFFSET - LOW_CYC;

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (div_out) begin
            hi_run <= hi_run + 16'd1;
        end else begin
            hi_run <= '0;
        end
    end

    // R4
    reset_high_chk: assert property (@(posedge clk)
        rst |=> (div_out && !cfg_err));

    // R3
    low_two_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(div_out) |=> !div_out);

    // R3
    low_two_max_chk: assert property (@(posedge clk) disable iff (rst)
        (!div_out && $past(!div_out)) |=> div_out);

    // R1
    high_bound_chk: assert property (@(posedge clk) disable iff (rst)
        hi_run <= 16'(HI_MAX));

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_word == '0) |=> cfg_err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

bind clkdiv_offset clkdiv_offset_chk #(
    .WORD_W  (WORD_W),
    .OFFSET  (OFFSET),
    .LOW_CYC (LOW_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ratio_word (ratio_word),
    .div_out    (div_out),
    .cfg_err    (cfg_err)
);

// File: tb/clkdiv_offset_test.sv
`timescale 1ns/100ps
module clkdiv_offset_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] ratio_word = 7'd1;
    logic       div_out;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    clkdiv_offset uut (
        .clk        (clk),
        .rst        (rst),
        .ratio_word (ratio_word),
        .div_out    (div_out),
        .cfg_err    (cfg_err)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 190000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply reset with a given word for one edge; check the reset state
    task automatic do_reset(input int w);
        @(negedge clk);
        rst = 1'b1;
        ratio_word = 7'(w);
        @(negedge clk);
        chk(div_out == 1'b1, "R4 reset level", int'(div_out), 1);
        chk(cfg_err == 1'b0, "R7 reset clears flag", int'(cfg_err), 0);
        rst = 1'b0;
    endtask

    // Count rising edges until div_out shows the wanted level
    task automatic edges_until(input bit lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (div_out != lvl && n < 400);
    endtask

    initial begin
        int k;
        int lo;
        int hi;

        // R1 R2 R3 R4: sweep every legal word
        for (int w = 1; w <= 127; w++) begin
            do_reset(w);
            edges_until(1'b0, k);
            chk(k == w, "R4 first low delay", k, w);
            edges_until(1'b1, lo);
            chk(lo == 2, "R3 low width", lo, 2);
            edges_until(1'b0, hi);
            chk(hi + lo == w + 2, "R1 R2 period", hi + lo, w + 2);
            chk(cfg_err == 1'b0, "R7 no flag for legal word", int'(cfg_err), 0);
        end

        // R3: ratio 20 gives 18 high of 20
        do_reset(18);
        edges_until(1'b0, k);
        edges_until(1'b1, lo);
        edges_until(1'b0, hi);
        chk(hi == 18, "R3 duty 90pct high cycles", hi, 18);

        // R5: word changed partway through the first period
        do_reset(18);
        repeat (5) @(negedge clk);
        ratio_word = 7'd40;
        edges_until(1'b0, k);
        chk(k == 13, "R5 current period kept", k + 5, 18);
        edges_until(1'b1, lo);
        edges_until(1'b0, hi);
        chk(hi + lo == 42, "R5 next period uses new word", hi + lo, 42);

        // R6 R7: zero word from reset
        do_reset(0);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R7 flag after zero word", int'(cfg_err), 1);
        chk(div_out == 1'b0, "R6 zero acts as ratio 3 first low", int'(div_out), 0);
        edges_until(1'b1, lo);
        edges_until(1'b0, hi);
        chk(hi + lo == 3, "R6 zero word period", hi + lo, 3);
        ratio_word = 7'd9;
        repeat (30) @(negedge clk);
        chk(cfg_err == 1'b1, "R7 flag sticky", int'(cfg_err), 1);

        // R7: zero word glimpsed mid-run after a legal reset
        do_reset(9);
        repeat (3) @(negedge clk);
        chk(cfg_err == 1'b0, "R7 clear before zero", int'(cfg_err), 0);
        ratio_word = 7'd0;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R7 set one edge after zero", int'(cfg_err), 1);
        ratio_word = 7'd9;
        do_reset(9);
        chk(cfg_err == 1'b0, "R7 cleared by reset", int'(cfg_err), 0);

        finish_run();
    end

endmodule